// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block arbitrates among five hardware interrupt levels for a processor that services interrupts in nested fashion. Each incoming request is captured in a pending flag that stays set until the level is granted, so no request is lost while it is masked or while higher-priority work is running. A per-level enable mask filters the pending flags, and the highest surviving level is offered to the processor. That offer is raised only when the level is strictly above the level now in service.

When the processor acknowledges the offer, the arbiter saves the running level on a small internal stack, clears the granted pending flag and makes the granted level current. When the handler signals end of service, the saved level is restored, so control drops back to the interrupted work once nothing higher remains. Because only a strictly higher level can interrupt, the stack never holds more than one frame per level. An end of service with nothing saved raises a sticky error flag and changes nothing else.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset no level is pending, the current level reads 7 (nothing in service), the request output is low, the granted level output reads 7 and the error flag is low.
- R2: A high bit i of the request input at a clock edge sets pending flag i, which stays set after the input falls until level i is acknowledged.
- R3: The granted level output carries the index of the highest pending enabled level, level 4 being the highest and level 0 the lowest, and reads 7 when no enabled level is pending.
- R4: Mask bit i set to 1 enables level i; a pending level whose mask bit is 0 is not offered and stays pending, and it is offered once its mask bit is set again (the mask input takes effect one clock after it is driven).
- R5: The request output is high only when the granted level is strictly above the current level, or when the current level is 7; same or lower levels never preempt, and the current level changes only on an accepted acknowledge or a pop.
- R6: An acknowledge while the request output is high makes the granted level current on the next clock, saves the previous current level and clears that level's pending flag; an acknowledge while the request output is low has no effect.
- R7: An end of service with a saved level restores the most recently saved level as the current level, so nested levels unwind in reverse order down to 7.
- R8: An end of service with no saved level sets a sticky error flag and leaves the current level unchanged.
- R9: A request arriving on the granted level in the same cycle as its acknowledge is latched as pending again.
- R10: When acknowledge is accepted in the same cycle as an end of service, the end of service is ignored.
- R11: The save stack holds up to five frames, enough for a full nest from idle through levels 0 to 4, and unwinding that nest returns to level 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 5 | Request inputs, one bit per level |
| mask_in | input | 5 | Level enables, 1 = enabled |
| ack | input | 1 | Processor takes the offered level |
| eos | input | 1 | Current handler has finished |
| int_req | output | 1 | Preemption request to the processor |
| grant_lvl | output | 3 | Highest pending enabled level, 7 if none |
| cur_lvl | output | 3 | Level in service, 7 if none |
| stk_err | output | 1 | Sticky flag: end of service with nothing saved |

## Verification
The assertions assume the processor acknowledges only to take an offer and signals end of service only while a handler runs; they tolerate stray acknowledges and an end of service on an empty stack, which are treated as defined behaviour. They take for granted that the stack is never pushed while full, which follows from strict-preemption and holds only if the level ordering is respected. The stimulus drives inputs half a cycle before each edge, pulses requests for single cycles, and unwinds every nest it builds before the next scenario, leaving the empty-stack error case to the end because the flag is sticky.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irqn_pending.sv
module irqn_pending #(
  parameter int NLVL = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_i,
  input  logic [NLVL-1:0] mask_i,
  input  logic [NLVL-1:0] clr_i,
  output logic [NLVL-1:0] pend_o,
  output logic [NLVL-1:0] mask_o
);
  logic [NLVL-1:0] pend_q;
  logic [NLVL-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      // new arrivals win over a clear in the same cycle
      pend_q <= (pend_q & ~clr_i) | irq_i;
      mask_q <= mask_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  // R4: a pending flag only drops when it was cleared
  p_pend_kept_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(pend_o) & ~$past(clr_i)) & ~pend_o) == '0));

  // R2: an arriving request is always visible next cycle
  p_req_latched_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(irq_i) & ~pend_o) == '0));
endmodule

// File: rtl/irqn_prio_enc.sv
module irqn_prio_enc #(
  parameter int NLVL = 5,
  parameter int LW   = 3,
  parameter logic [LW-1:0] IDLE = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] elig_i,
  output logic            any_o,
  output logic [LW-1:0]   lvl_o,
  output logic [NLVL-1:0] onehot_o
);
  logic [NLVL-1:0] higher_set;

  // higher_set[i]: some level above i is eligible
  assign higher_set[NLVL-1] = 1'b0;
  for (genvar g = NLVL - 2; g >= 0; g--) begin : g_chain
    assign higher_set[g] = higher_set[g+1] | elig_i[g+1];
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_pick
    assign onehot_o[g] = elig_i[g] & ~higher_set[g];
  end

  always_comb begin
    lvl_o = IDLE;
    for (int i = 0; i < NLVL; i++) begin
      if (onehot_o[i]) lvl_o = LW'(i);
    end
  end

  assign any_o = |elig_i;

  // R3: exactly one winner when anything is eligible
  p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(onehot_o) && (any_o == ($countones(onehot_o) == 1)));

  // R3: the winner is itself eligible
  p_winner_elig_r3: assert property (@(posedge clk) disable iff (rst)
    (onehot_o & ~elig_i) == '0);
endmodule

// File: rtl/irqn_level_stack.sv
module irqn_level_stack
  import irqn_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int LW    = 3,
  parameter logic [LW-1:0] IDLE = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  stk_op_e       op_i,
  input  logic [LW-1:0] push_val_i,
  output logic [LW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  top_addr;

  assign empty_o  = (sp_q == '0);
  assign full_o   = (sp_q == SPW'(DEPTH));
  assign top_addr = empty_o ? '0 : AW'(sp_q - 1'b1);
  assign top_o    = empty_o ? IDLE : mem[top_addr];

  // memory without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (op_i == STK_PUSH && !full_o) mem[AW'(sp_q)] <= push_val_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else begin
      case (op_i)
        STK_PUSH: if (!full_o)  sp_q <= sp_q + 1'b1;
        STK_POP:  if (!empty_o) sp_q <= sp_q - 1'b1;
        default:  sp_q <= sp_q;
      endcase
    end
  end

  // R11: depth never exceeds one frame per level
  p_depth_bound_r11: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));

  // R11: strict preemption means a push never meets a full stack
  p_no_push_full_r11: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_PUSH) |-> !full_o);

  // R7: a pop lowers the depth by one
  p_pop_depth_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i == STK_POP && !empty_o) |=> (sp_q == $past(sp_q) - 1'b1));
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irqn_pkg::*;
#(
  parameter int NLVL = 5,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NLVL-1:0] irq_in,
  input  logic [NLVL-1:0] mask_in,
  input  logic            ack,
  input  logic            eos,
  output logic            int_req,
  output logic [LW-1:0]   grant_lvl,
  output logic [LW-1:0]   cur_lvl,
  output logic            stk_err
);
  localparam logic [LW-1:0] IDLE = '1;

  logic [NLVL-1:0] pend, mask_q, elig, win_oh, clr;
  logic            any_elig;
  logic [LW-1:0]   win_lvl;
  logic [LW-1:0]   cur_q;
  logic            err_q;
  logic            take, pop, empty_pop;
  logic [LW-1:0]   stk_top;
  logic            stk_empty, stk_full;
  stk_op_e         op;

  irqn_pending #(.NLVL(NLVL)) u_pend (
    .clk(clk), .rst(rst), .irq_i(irq_in), .mask_i(mask_in),
    .clr_i(clr), .pend_o(pend), .mask_o(mask_q)
  );

  assign elig = pend & mask_q;

  irqn_prio_enc #(.NLVL(NLVL), .LW(LW), .IDLE(IDLE)) u_enc (
    .clk(clk), .rst(rst), .elig_i(elig), .any_o(any_elig),
    .lvl_o(win_lvl), .onehot_o(win_oh)
  );

  assign int_req   = any_elig && ((cur_q == IDLE) || (win_lvl > cur_q));
  assign grant_lvl = win_lvl;

  assign take      = ack && int_req;
  assign pop       = eos && !take && !stk_empty;
  assign empty_pop = eos && !take && stk_empty;
  assign clr       = take ? win_oh : '0;
  assign op        = take ? STK_PUSH : (pop ? STK_POP : STK_HOLD);

  irqn_level_stack #(.DEPTH(NLVL), .LW(LW), .IDLE(IDLE)) u_stk (
    .clk(clk), .rst(rst), .op_i(op), .push_val_i(cur_q),
    .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= IDLE;
      err_q <= 1'b0;
    end else begin
      if (take)     cur_q <= win_lvl;
      else if (pop) cur_q <= stk_top;
      if (empty_pop) err_q <= 1'b1;
    end
  end

  assign cur_lvl = cur_q;
  assign stk_err = err_q;

  // R6: accepted acknowledge installs the offered level
  p_ack_sets_cur_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> (cur_lvl == $past(grant_lvl)));

  // R7: a pop restores the saved level
  p_pop_restores_r7: assert property (@(posedge clk) disable iff (rst)
    pop |=> (cur_lvl == $past(stk_top)));

  // R5: current level moves only on acknowledge or pop
  p_cur_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (!take && !pop) |=> $stable(cur_lvl));

  // R8: nothing saved means nothing in service
  p_idle_empty_r8: assert property (@(posedge clk) disable iff (rst)
    stk_empty |-> (cur_lvl == IDLE));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(stk_err) |-> stk_err);

  // R11: when the stack is full the top level is in service
  p_full_top_r11: assert property (@(posedge clk) disable iff (rst)
    stk_full |-> (cur_lvl == LW'(NLVL - 1)));
endmodule

// File: tb/irq_nest_arbiter_bench.sv
`timescale 1ns/1ps
module irq_nest_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] irq_in, mask_in;
  logic       ack, eos;
  logic       int_req, stk_err;
  logic [2:0] grant_lvl, cur_lvl;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_nest_arbiter u_irq_nest_arbiter (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_in(mask_in),
    .ack(ack), .eos(eos), .int_req(int_req), .grant_lvl(grant_lvl),
    .cur_lvl(cur_lvl), .stk_err(stk_err)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_irq(input logic [4:0] v);
    irq_in = v; tick(); irq_in = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic do_eos();
    eos = 1'b1; tick(); eos = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 int_req", int_req, 0);
    chk_eq("R1 cur_lvl", cur_lvl, 7);
    chk_eq("R1 grant_lvl", grant_lvl, 7);
    chk_eq("R1 stk_err", stk_err, 0);
  endtask

  task automatic t_ack_ignored();
    do_ack();
    chk_eq("R6 stray ack cur", cur_lvl, 7);
    chk_eq("R6 stray ack req", int_req, 0);
  endtask

  task automatic t_latch_prio();
    pulse_irq(5'b00101);
    chk_eq("R2 req after pulse", int_req, 1);
    chk_eq("R3 highest wins", grant_lvl, 2);
    do_ack();
    chk_eq("R6 cur after ack", cur_lvl, 2);
    chk_eq("R3 next grant", grant_lvl, 0);
    chk_eq("R5 lower no preempt", int_req, 0);
    pulse_irq(5'b00100);
    chk_eq("R5 same no preempt", int_req, 0);
    do_eos();
    chk_eq("R7 back to idle", cur_lvl, 7);
    chk_eq("R2 level2 kept", grant_lvl, 2);
    do_ack(); do_eos();
    chk_eq("R2 level0 still pending", grant_lvl, 0);
    do_ack();
    chk_eq("R6 cur level0", cur_lvl, 0);
    do_eos();
    chk_eq("R6 pending cleared", int_req, 0);
  endtask

  task automatic t_mask();
    mask_in = 5'b11110; tick();
    pulse_irq(5'b00001);
    chk_eq("R4 masked not offered", int_req, 0);
    chk_eq("R4 masked grant", grant_lvl, 7);
    mask_in = 5'b11111; tick();
    chk_eq("R4 offered after unmask", int_req, 1);
    chk_eq("R4 grant after unmask", grant_lvl, 0);
    do_ack(); do_eos();
  endtask

  task automatic t_nest();
    pulse_irq(5'b00010); do_ack();
    pulse_irq(5'b01000);
    chk_eq("R5 higher preempts", int_req, 1);
    do_ack();
    chk_eq("R6 nest cur3", cur_lvl, 3);
    pulse_irq(5'b10000); do_ack();
    chk_eq("R6 nest cur4", cur_lvl, 4);
    do_eos(); chk_eq("R7 unwind 3", cur_lvl, 3);
    do_eos(); chk_eq("R7 unwind 1", cur_lvl, 1);
    do_eos(); chk_eq("R7 unwind idle", cur_lvl, 7);
  endtask

  task automatic t_same_cycle();
    pulse_irq(5'b00100);
    irq_in = 5'b00100; do_ack(); irq_in = '0;
    chk_eq("R9 cur2", cur_lvl, 2);
    do_eos();
    chk_eq("R9 relatched req", int_req, 1);
    chk_eq("R9 relatched grant", grant_lvl, 2);
    do_ack(); do_eos();
    chk_eq("R9 drained", int_req, 0);
  endtask

  task automatic t_ack_eos();
    pulse_irq(5'b00010); do_ack();
    pulse_irq(5'b01000);
    ack = 1'b1; eos = 1'b1; tick(); ack = 1'b0; eos = 1'b0;
    chk_eq("R10 ack wins", cur_lvl, 3);
    do_eos(); chk_eq("R10 stack intact", cur_lvl, 1);
    do_eos(); chk_eq("R10 idle", cur_lvl, 7);
    chk_eq("R10 no error", stk_err, 0);
  endtask

  task automatic t_depth();
    for (int i = 0; i < 5; i++) begin
      pulse_irq(5'(1 << i)); do_ack();
    end
    chk_eq("R11 full nest cur4", cur_lvl, 4);
    for (int i = 3; i >= -1; i--) begin
      do_eos();
      chk_eq("R11 unwind", cur_lvl, (i < 0) ? 7 : i);
    end
    chk_eq("R11 no error", stk_err, 0);
  endtask

  task automatic t_empty();
    do_eos();
    chk_eq("R8 error set", stk_err, 1);
    chk_eq("R8 cur unchanged", cur_lvl, 7);
    tick();
    chk_eq("R8 error sticky", stk_err, 1);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
    rst = 1'b1; irq_in = '0; mask_in = 5'b11111; ack = 1'b0; eos = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_ack_ignored();
    t_latch_prio();
    t_mask();
    t_nest();
    t_same_cycle();
    t_ack_eos();
    t_depth();
    t_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule